// File: doc/BRIEF.md
# Dual-Channel Host Bus Decoder

This block sits between an 8-bit asynchronous host bus and the register files of a two-channel serial port. The host drives an active-low chip select, a channel-select line, a 3-bit register address, a data byte and active-low read and write strobes. The block brings the strobes into the local clock domain and turns each host write into a single-cycle write enable, with address and data, for channel A, for channel B, or for both at once. It turns the start of each host read into a single-cycle read strobe for the selected channel, and it returns that channel's addressed register byte on a registered read-data output. An output-enable qualifies that output so that the pad ring can tristate the shared data bus.

Each channel holds a 3-bit alternate-function field in its register file, and the block receives a copy of it. The lowest bit of that field enables broadcast writes. The upper two bits choose what the channel's active-low multi-function pin shows: the inverted general-purpose output bit, the baud clock, or receive-ready. Each channel's interrupt request leaves the block active high through one register stage. Every output is registered and clears on the synchronous active-high reset.

Top module: `dual_host_decoder`

## Requirements
- R1: While reset is held, `wr_en_a`, `wr_en_b`, `rd_stb_a`, `rd_stb_b`, `bus_doe`, `irq_a` and `irq_b` are 0 and `mf_n_a` and `mf_n_b` are 1.
- R2: Consider a host write with `bus_cs_n` low and broadcast off. With `bus_chsel`=1 it gives exactly one `wr_en_a` pulse and no `wr_en_b`. With `bus_chsel`=0 it gives exactly one `wr_en_b` pulse and no `wr_en_a`. The pulse carries the address and byte that the host held while the write strobe was low.
- R3: A write strobe given while `bus_cs_n` is high produces no write enable on either channel, and it leaves both register banks unchanged.
- R4: When bit 0 of `afr_a` or of `afr_b` is 1, a selected write pulses `wr_en_a` and `wr_en_b` in the same cycle with the same address and data, whatever the level of `bus_chsel`. Both enables high together happens only in this case.
- R5: `bus_doe` is 1 only while chip select and the read strobe are both held low, and it returns to 0 after either one rises. While `bus_doe` is 1, `bus_dout` holds the addressed register of channel A when `bus_chsel`=1 and of channel B when `bus_chsel`=0.
- R6: With broadcast set, reads still return the register of the channel chosen by `bus_chsel`.
- R7: Each selected read gives exactly one single-cycle `rd_stb` pulse, on the chosen channel only. A read strobe with chip select high gives none.
- R8: When a channel's alternate-function bits [2:1] are 00 or 11, its `mf_n` output is the inverse of its `op2` input, one cycle later.
- R9: When the bits [2:1] are 01, `mf_n` is the inverse of the channel's `baud` input, one cycle later.
- R10: When the bits [2:1] are 10, `mf_n` is the inverse of the channel's `rxrdy` input, one cycle later.
- R11: `irq_a` and `irq_b` are active high and follow `irq_in_a` and `irq_in_b` with a delay of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_chsel | input | 1 | Channel select, 1 = A, 0 = B |
| bus_addr | input | 3 | Host register address |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Read data toward the host |
| bus_doe | output | 1 | Data bus drive enable |
| reg_rd_addr | output | 3 | Register address for read data |
| rd_data_a | input | 8 | Channel A register byte at `reg_rd_addr` |
| rd_data_b | input | 8 | Channel B register byte at `reg_rd_addr` |
| rd_stb_a | output | 1 | Channel A read-start pulse |
| rd_stb_b | output | 1 | Channel B read-start pulse |
| reg_wr_addr | output | 3 | Write address |
| reg_wr_data | output | 8 | Write data |
| wr_en_a | output | 1 | Channel A write enable |
| wr_en_b | output | 1 | Channel B write enable |
| afr_a | input | 3 | Channel A alternate-function field |
| afr_b | input | 3 | Channel B alternate-function field |
| op2_a | input | 1 | Channel A general-purpose output bit |
| op2_b | input | 1 | Channel B general-purpose output bit |
| baud_a | input | 1 | Channel A baud clock |
| baud_b | input | 1 | Channel B baud clock |
| rxrdy_a | input | 1 | Channel A receive-ready, active high |
| rxrdy_b | input | 1 | Channel B receive-ready, active high |
| mf_n_a | output | 1 | Channel A multi-function pin, active low |
| mf_n_b | output | 1 | Channel B multi-function pin, active low |
| irq_in_a | input | 1 | Channel A interrupt request |
| irq_in_b | input | 1 | Channel B interrupt request |
| irq_a | output | 1 | Channel A interrupt, active high |
| irq_b | output | 1 | Channel B interrupt, active high |

## Verification
Two things can happen in the same clock cycle: a broadcast write commit that updates both channels, and a change of selector on the multi-function pins. Both are driven by the same alternate-function field. The bench turns on broadcast and a new pin selector together and then issues a write on one channel-select level. It judges the result by comparing both bench register banks against a model filled from the requirements, and by checking the pin levels under the new selector. A further sweep reads every address on both channels while broadcast is still on. It checks that the broadcast bit leaves the choice of channel for reads unchanged.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic [1:0] {
    MF_GPO   = 2'b00,
    MF_BAUD  = 2'b01,
    MF_RXRDY = 2'b10,
    MF_GPO2  = 2'b11
  } mf_sel_e;

  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam int NUM_CH = 2;
  localparam int AFR_W = 3;
endpackage

// File: rtl/sync_bit.sv
module sync_bit #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mf_out_sel.sv
module mf_out_sel
  import hbd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  mf_sel_e sel,
  input  logic    op2,
  input  logic    baud,
  input  logic    rxrdy,
  output logic    mf_n
);
  logic pick;

  always_comb begin
    unique case (sel)
      MF_BAUD:  pick = baud;
      MF_RXRDY: pick = rxrdy;
      default:  pick = op2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mf_n <= 1'b1;
    else     mf_n <= ~pick;
  end
endmodule

// File: rtl/dual_host_decoder.sv
module dual_host_decoder
  import hbd_pkg::*;
#(
  parameter int AW          = 3,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_chsel,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic [AW-1:0] reg_rd_addr,
  input  logic [DW-1:0] rd_data_a,
  input  logic [DW-1:0] rd_data_b,
  output logic          rd_stb_a,
  output logic          rd_stb_b,
  output logic [AW-1:0] reg_wr_addr,
  output logic [DW-1:0] reg_wr_data,
  output logic          wr_en_a,
  output logic          wr_en_b,
  input  logic [2:0]    afr_a,
  input  logic [2:0]    afr_b,
  input  logic          op2_a,
  input  logic          op2_b,
  input  logic          baud_a,
  input  logic          baud_b,
  input  logic          rxrdy_a,
  input  logic          rxrdy_b,
  output logic          mf_n_a,
  output logic          mf_n_b,
  input  logic          irq_in_a,
  input  logic          irq_in_b,
  output logic          irq_a,
  output logic          irq_b
);
  // strobe and select synchronizers
  logic rd_s, wr_s, cs_s, ch_s;

  sync_bit #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_rd_sync (.clk(clk), .rst(rst), .d(bus_rd_n),  .q(rd_s));
  sync_bit #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_wr_sync (.clk(clk), .rst(rst), .d(bus_wr_n),  .q(wr_s));
  sync_bit #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (.clk(clk), .rst(rst), .d(bus_cs_n),  .q(cs_s));
  sync_bit #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_ch_sync (.clk(clk), .rst(rst), .d(bus_chsel), .q(ch_s));

  // edge detection on synchronized strobes
  logic rd_prev, wr_prev;
  logic rd_fall, wr_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b1;
      wr_prev <= 1'b1;
    end else begin
      rd_prev <= rd_s;
      wr_prev <= wr_s;
    end
  end

  assign rd_fall = rd_prev & ~rd_s;
  assign wr_rise = ~wr_prev & wr_s;

  // write capture: follow the bus while the strobe is low
  logic [AW-1:0] wr_addr_l;
  logic [DW-1:0] wr_data_l;
  logic          wr_sel_l;
  logic          wr_ch_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr_l <= '0;
      wr_data_l <= '0;
      wr_sel_l  <= 1'b0;
      wr_ch_l   <= 1'b0;
    end else if (!wr_s) begin
      wr_addr_l <= bus_addr;
      wr_data_l <= bus_din;
      wr_sel_l  <= ~cs_s;
      wr_ch_l   <= ch_s;
    end
  end

  logic bcast;
  assign bcast = afr_a[0] | afr_b[0];

  // per-channel select decode (index CH_A answers chsel=1)
  logic [NUM_CH-1:0] wr_pick, rd_pick;
  assign wr_pick[CH_A] = wr_ch_l;
  assign wr_pick[CH_B] = ~wr_ch_l;
  assign rd_pick[CH_A] = ch_s;
  assign rd_pick[CH_B] = ~ch_s;

  logic [NUM_CH-1:0] wr_en_q, rd_stb_q, irq_q, irq_in_v, mf_n_v;
  logic [NUM_CH-1:0] op2_v, baud_v, rxrdy_v;
  mf_sel_e           mf_sel_v [NUM_CH];

  assign irq_in_v[CH_A] = irq_in_a;
  assign irq_in_v[CH_B] = irq_in_b;
  assign op2_v[CH_A]    = op2_a;
  assign op2_v[CH_B]    = op2_b;
  assign baud_v[CH_A]   = baud_a;
  assign baud_v[CH_B]   = baud_b;
  assign rxrdy_v[CH_A]  = rxrdy_a;
  assign rxrdy_v[CH_B]  = rxrdy_b;
  assign mf_sel_v[CH_A] = mf_sel_e'(afr_a[2:1]);
  assign mf_sel_v[CH_B] = mf_sel_e'(afr_b[2:1]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        wr_en_q[i]  <= 1'b0;
        rd_stb_q[i] <= 1'b0;
        irq_q[i]    <= 1'b0;
      end else begin
        wr_en_q[i]  <= wr_rise & wr_sel_l & (bcast | wr_pick[i]);
        rd_stb_q[i] <= rd_fall & ~cs_s & rd_pick[i];
        irq_q[i]    <= irq_in_v[i];
      end
    end

    mf_out_sel u_mf (
      .clk  (clk),
      .rst  (rst),
      .sel  (mf_sel_v[i]),
      .op2  (op2_v[i]),
      .baud (baud_v[i]),
      .rxrdy(rxrdy_v[i]),
      .mf_n (mf_n_v[i])
    );
  end

  // write address and data register
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
    end else if (wr_rise) begin
      reg_wr_addr <= wr_addr_l;
      reg_wr_data <= wr_data_l;
    end
  end

  // read path
  logic rd_ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_addr <= '0;
      rd_ch_q     <= 1'b0;
      bus_dout    <= '0;
      bus_doe     <= 1'b0;
    end else begin
      reg_rd_addr <= bus_addr;
      rd_ch_q     <= ch_s;
      bus_dout    <= rd_ch_q ? rd_data_a : rd_data_b;
      bus_doe     <= ~rd_s & ~cs_s;
    end
  end

  assign wr_en_a  = wr_en_q[CH_A];
  assign wr_en_b  = wr_en_q[CH_B];
  assign rd_stb_a = rd_stb_q[CH_A];
  assign rd_stb_b = rd_stb_q[CH_B];
  assign irq_a    = irq_q[CH_A];
  assign irq_b    = irq_q[CH_B];
  assign mf_n_a   = mf_n_v[CH_A];
  assign mf_n_b   = mf_n_v[CH_B];
endmodule

// File: rtl/hbd_chk.sv
module hbd_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en_a,
  input logic       wr_en_b,
  input logic       rd_stb_a,
  input logic       rd_stb_b,
  input logic [2:0] afr_a,
  input logic       op2_a,
  input logic       baud_a,
  input logic       rxrdy_a,
  input logic       mf_n_a,
  input logic       irq_in_a,
  input logic       irq_a,
  input logic       irq_in_b,
  input logic       irq_b,
  input logic       bcast_in
);
  // R2
  wr_a_single_chk: assert property (@(posedge clk) disable iff (rst) wr_en_a |=> !wr_en_a);
  // R2
  wr_b_single_chk: assert property (@(posedge clk) disable iff (rst) wr_en_b |=> !wr_en_b);
  // R4
  dual_wr_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_a && wr_en_b) |-> $past(bcast_in));
  // R7
  rd_one_ch_chk: assert property (@(posedge clk) disable iff (rst) !(rd_stb_a && rd_stb_b));
  // R7
  rd_a_single_chk: assert property (@(posedge clk) disable iff (rst) rd_stb_a |=> !rd_stb_a);
  // R8
  mf_gpo_chk: assert property (@(posedge clk) disable iff (rst)
    (afr_a[2:1] == 2'b00 || afr_a[2:1] == 2'b11) |=> (mf_n_a == !$past(op2_a)));
  // R9
  mf_baud_chk: assert property (@(posedge clk) disable iff (rst)
    (afr_a[2:1] == 2'b01) |=> (mf_n_a == !$past(baud_a)));
  // R10
  mf_rxrdy_chk: assert property (@(posedge clk) disable iff (rst)
    (afr_a[2:1] == 2'b10) |=> (mf_n_a == !$past(rxrdy_a)));
  // R11
  irq_a_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_a == $past(irq_in_a)));
  // R11
  irq_b_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_b == $past(irq_in_b)));
endmodule

bind dual_host_decoder hbd_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en_a (wr_en_a),
  .wr_en_b (wr_en_b),
  .rd_stb_a(rd_stb_a),
  .rd_stb_b(rd_stb_b),
  .afr_a   (afr_a),
  .op2_a   (op2_a),
  .baud_a  (baud_a),
  .rxrdy_a (rxrdy_a),
  .mf_n_a  (mf_n_a),
  .irq_in_a(irq_in_a),
  .irq_a   (irq_a),
  .irq_in_b(irq_in_b),
  .irq_b   (irq_b),
  .bcast_in(afr_a[0] | afr_b[0])
);

// File: tb/sim_dual_host_decoder.sv
`timescale 1ns/1ps
module sim_dual_host_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       bus_cs_n = 1'b1, bus_chsel = 1'b0, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout, rd_data_a, rd_data_b, reg_wr_data;
  logic [2:0] reg_rd_addr, reg_wr_addr;
  logic       bus_doe, rd_stb_a, rd_stb_b, wr_en_a, wr_en_b;
  logic [2:0] afr_a = '0, afr_b = '0;
  logic       op2_a = 0, op2_b = 0, baud_a = 0, baud_b = 0, rxrdy_a = 0, rxrdy_b = 0;
  logic       mf_n_a, mf_n_b, irq_in_a = 0, irq_in_b = 0, irq_a, irq_b;

  dual_host_decoder u0 (.*);

  // register banks standing in for the two channels
  logic [7:0] bank_a [8];
  logic [7:0] bank_b [8];
  logic [7:0] exp_a [8];
  logic [7:0] exp_b [8];
  int n_wa = 0, n_wb = 0, n_wab = 0, n_ra = 0, n_rb = 0;

  assign rd_data_a = bank_a[reg_rd_addr];
  assign rd_data_b = bank_b[reg_rd_addr];

  always @(posedge clk) begin
    if (wr_en_a) begin bank_a[reg_wr_addr] <= reg_wr_data; n_wa <= n_wa + 1; end
    if (wr_en_b) begin bank_b[reg_wr_addr] <= reg_wr_data; n_wb <= n_wb + 1; end
    if (wr_en_a && wr_en_b) n_wab <= n_wab + 1;
    if (rd_stb_a) n_ra <= n_ra + 1;
    if (rd_stb_b) n_rb <= n_rb + 1;
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pattern(input int a, input int c, input int pass);
    return 8'((a * 29 + c * 101 + pass * 7) ^ 8'hA5);
  endfunction

  task automatic host_write(input bit cs_n, input bit ch, input logic [2:0] a,
                            input logic [7:0] d, input string req);
    int wa0, wb0, wab0;
    bit bc;
    bit ea, eb;
    wa0 = n_wa; wb0 = n_wb; wab0 = n_wab;
    bc = afr_a[0] | afr_b[0];
    bus_cs_n = cs_n; bus_chsel = ch; bus_addr = a; bus_din = d;
    idle(3);
    bus_wr_n = 1'b0;
    idle(4);
    bus_wr_n = 1'b1;
    idle(5);
    bus_cs_n = 1'b1;
    idle(3);
    ea = !cs_n && (bc || ch);
    eb = !cs_n && (bc || !ch);
    if (ea) exp_a[a] = d;
    if (eb) exp_b[a] = d;
    chk((n_wa - wa0) == int'(ea), req, n_wa - wa0, int'(ea));
    chk((n_wb - wb0) == int'(eb), req, n_wb - wb0, int'(eb));
    chk((n_wab - wab0) == int'(ea && eb), req, n_wab - wab0, int'(ea && eb));
  endtask

  task automatic host_read(input bit ch, input logic [2:0] a, input string req);
    int ra0, rb0;
    logic [7:0] e;
    ra0 = n_ra; rb0 = n_rb;
    bus_cs_n = 1'b0; bus_chsel = ch; bus_addr = a;
    idle(3);
    chk(bus_doe == 1'b0, {req, " doe before strobe"}, bus_doe, 0);
    bus_rd_n = 1'b0;
    idle(6);
    e = ch ? exp_a[a] : exp_b[a];
    chk(bus_doe == 1'b1, {req, " doe"}, bus_doe, 1);
    chk(bus_dout == e, {req, " data"}, bus_dout, e);
    bus_rd_n = 1'b1;
    idle(5);
    chk(bus_doe == 1'b0, {req, " doe release"}, bus_doe, 0);
    chk((n_ra - ra0) == int'(ch) && (n_rb - rb0) == int'(!ch), "R7 read strobe",
        (n_ra - ra0) * 16 + (n_rb - rb0), int'(ch) * 16 + int'(!ch));
    bus_cs_n = 1'b1;
    idle(3);
  endtask

  task automatic read_all(input string req);
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++)
        host_read(c[0], 3'(a), req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      bank_a[i] = '0; bank_b[i] = '0; exp_a[i] = '0; exp_b[i] = '0;
    end
    irq_in_a = 1; irq_in_b = 1; op2_a = 1; op2_b = 1;
    idle(6);
    // R1: reset state while reset held
    chk(!wr_en_a && !wr_en_b && !rd_stb_a && !rd_stb_b, "R1 enables", {wr_en_a, wr_en_b, rd_stb_a, rd_stb_b}, 0);
    chk(!bus_doe && !irq_a && !irq_b, "R1 doe/irq", {bus_doe, irq_a, irq_b}, 0);
    chk(mf_n_a && mf_n_b, "R1 mf pins", {mf_n_a, mf_n_b}, 3);
    irq_in_a = 0; irq_in_b = 0; op2_a = 0; op2_b = 0;
    rst = 1'b0;
    idle(4);

    // R2: single-channel writes over all addresses, both channels
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++)
        host_write(1'b0, c[0], 3'(a), pattern(a, c, 1), "R2 write");
    // R5: read back everything
    read_all("R5 read");

    // R3: writes with chip select high are ignored
    for (int a = 0; a < 8; a += 3) host_write(1'b1, a[0], 3'(a), 8'hEE, "R3 deselected write");
    afr_b = 3'b001;
    host_write(1'b1, 1'b0, 3'd5, 8'h3C, "R3 deselected broadcast");
    afr_b = 3'b000;
    read_all("R3 banks unchanged");

    // R7: read with chip select high gives no strobe and no drive
    begin
      int ra0, rb0;
      ra0 = n_ra; rb0 = n_rb;
      bus_cs_n = 1'b1; bus_rd_n = 1'b0;
      idle(8);
      chk(bus_doe == 1'b0, "R5 doe with cs high", bus_doe, 0);
      bus_rd_n = 1'b1;
      idle(4);
      chk(n_ra == ra0 && n_rb == rb0, "R7 no strobe with cs high", (n_ra - ra0) + (n_rb - rb0), 0);
    end

    // R4 with simultaneous selector change on the pins (R9)
    afr_a = 3'b011; afr_b = 3'b001; baud_a = 1; baud_b = 0;
    for (int a = 0; a < 8; a++)
      host_write(1'b0, a[0], 3'(a), pattern(a, 2, 3), "R4 broadcast write");
    chk(mf_n_a == 1'b0, "R9 mf A during broadcast", mf_n_a, 0);
    chk(mf_n_b == 1'b1, "R8 mf B during broadcast", mf_n_b, 1);
    // R6: reads still follow channel select
    read_all("R6 read under broadcast");
    afr_a = 3'b000; afr_b = 3'b000;
    idle(2);

    // R8 R9 R10: selector sweep on both channels
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 8; v++) begin
        bit e;
        afr_a = {2'(s), 1'b0}; afr_b = {2'(s), 1'b0};
        {op2_a, baud_a, rxrdy_a} = 3'(v);
        {op2_b, baud_b, rxrdy_b} = ~3'(v);
        idle(2);
        e = (s == 1) ? !v[1] : (s == 2) ? !v[0] : !v[2];
        chk(mf_n_a == e, (s == 1) ? "R9 mf A" : (s == 2) ? "R10 mf A" : "R8 mf A", mf_n_a, e);
        chk(mf_n_b == !e, (s == 1) ? "R9 mf B" : (s == 2) ? "R10 mf B" : "R8 mf B", mf_n_b, !e);
      end

    // R11: interrupt pass-through
    for (int v = 0; v < 4; v++) begin
      irq_in_a = v[0]; irq_in_b = v[1];
      idle(2);
      chk(irq_a == v[0] && irq_b == v[1], "R11 irq", {irq_b, irq_a}, v);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule